// File: doc/BRIEF.md
# Pipelined Parent Branch-Metric Unit

This block produces, once per trellis stage, the four parent branch metrics that an eight-state turbo constituent decoder needs for its forward and backward state-metric updates and for its output likelihood calculation. It takes three signed log-likelihood ratios: the a-priori value for the information bit, the systematic channel value and the first parity channel value. The channel reliability factor is fixed at two, so the channel values enter without any multiplier. The a-priori value is halved by a one-bit arithmetic right shift.

The datapath is feed-forward and has two register stages. The first stage registers the halved a-priori value together with the sum and the difference of the two channel values. The second stage adds the halved a-priori value to the chosen term. The metrics for an information bit of zero are then negated by inversion plus one. A valid flag moves through the pipeline in step with the data. The data registers of a stage load only when that stage receives a valid sample, so a bubble leaves the previous metrics on the outputs. The outputs are two bits wider than the inputs, which makes every result exact for full-scale inputs.

Top module: `bm_parent_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and all four metric outputs are 0.
- R2: `bm_u1p1` equals h + s + p, where h is the a-priori input shifted right by one bit arithmetically, s is the systematic input and p is the parity input, all sampled two cycles earlier.
- R3: `bm_u1p0` equals h + s − p.
- R4: `bm_u0p1` equals −h − s + p.
- R5: `bm_u0p0` equals −h − s − p.
- R6: `out_valid` in cycle n+2 equals `in_valid` in cycle n. Latency is exactly two clock cycles and back-to-back samples are accepted every cycle.
- R7: A cycle with `in_valid` low has no effect on the metric outputs, whatever values its data inputs carry. The metrics keep the values of the last valid sample while `out_valid` is low.
- R8: Full-scale inputs (−128 and +127 at the default 8-bit width) give exact results with no wrap. The outputs are LLR width + 2 bits, two's complement.
- R9: The halving rounds toward minus infinity. An odd negative a-priori value such as −3 contributes −2, and −1 contributes −1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks the input LLRs as a new trellis-stage sample |
| apriori_llr | input | LLR_W | A-priori LLR of the information bit, signed |
| sys_llr | input | LLR_W | Systematic channel LLR, signed |
| par_llr | input | LLR_W | First parity channel LLR, signed |
| out_valid | output | 1 | Marks the metric outputs as new |
| bm_u0p0 | output | LLR_W+2 | Metric for information bit 0 and parity 0, signed |
| bm_u0p1 | output | LLR_W+2 | Metric for information bit 0 and parity 1, signed |
| bm_u1p0 | output | LLR_W+2 | Metric for information bit 1 and parity 0, signed |
| bm_u1p1 | output | LLR_W+2 | Metric for information bit 1 and parity 1, signed |

## Verification
While samples stream back to back, the second stage combines sample n in the same cycle in which the first stage captures sample n+1. A fault in the stage enables or in the valid chain would therefore mix two samples. The bench drives a new vector on every cycle of its table walk and checks each output set against the vector it sent exactly two cycles earlier. It then sends bubbles whose data inputs carry nonzero values and confirms that the last valid metrics stay on the outputs while `out_valid` is low.

// File: rtl/bm_pkg.sv
package bm_pkg;

    // Number of parent metrics per trellis stage and the pipeline depth.
    localparam int unsigned BM_COUNT   = 4;
    localparam int unsigned BM_LATENCY = 2;

    // Metric index: bit 1 is the information bit, bit 0 is the parity bit.
    typedef enum logic [1:0] {
        BM_U0_P0 = 2'd0,
        BM_U0_P1 = 2'd1,
        BM_U1_P0 = 2'd2,
        BM_U1_P1 = 2'd3
    } bm_sel_e;

    function automatic int unsigned info_bit(int unsigned idx);
        return (idx >> 1) & 1;
    endfunction

    function automatic int unsigned par_bit(int unsigned idx);
        return idx & 1;
    endfunction

endpackage

// File: rtl/bm_front_stage.sv
module bm_front_stage #(
    parameter int unsigned LLR_W = 8,
    parameter int unsigned SUM_W = LLR_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [LLR_W-1:0] la_in,
    input  logic signed [LLR_W-1:0] ls_in,
    input  logic signed [LLR_W-1:0] lp_in,
    output logic                    v_q,
    output logic signed [LLR_W-1:0] half_q,
    output logic signed [SUM_W-1:0] sum_q,
    output logic signed [SUM_W-1:0] diff_q
);

    logic signed [LLR_W-1:0] half_d;
    logic signed [SUM_W-1:0] sum_d;
    logic signed [SUM_W-1:0] diff_d;

    always_comb begin
        half_d = la_in >>> 1;
        sum_d  = SUM_W'(ls_in) + SUM_W'(lp_in);
        diff_d = SUM_W'(ls_in) - SUM_W'(lp_in);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q    <= 1'b0;
            half_q <= '0;
            sum_q  <= '0;
            diff_q <= '0;
        end else begin
            v_q <= in_valid;
            if (in_valid) begin
                half_q <= half_d;
                sum_q  <= sum_d;
                diff_q <= diff_d;
            end
        end
    end

    // R3: sum and difference registers differ by twice the captured parity
    p_sum_diff_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (int'(sum_q) - int'(diff_q)) == 2 * int'($past(lp_in)));

    // R9: captured half is the floor of half the a-priori input
    p_half_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (2 * int'(half_q) == int'($past(la_in)))
                  || (2 * int'(half_q) + 1 == int'($past(la_in))));

endmodule

// File: rtl/bm_sign_stage.sv
module bm_sign_stage
    import bm_pkg::*;
#(
    parameter int unsigned LLR_W = 8,
    parameter int unsigned SUM_W = LLR_W + 1,
    parameter int unsigned OUT_W = LLR_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    v_in,
    input  logic signed [LLR_W-1:0] half_in,
    input  logic signed [SUM_W-1:0] sum_in,
    input  logic signed [SUM_W-1:0] diff_in,
    output logic                    v_q,
    output logic signed [OUT_W-1:0] bm_q [BM_COUNT]
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q <= 1'b0;
        end else begin
            v_q <= v_in;
        end
    end

    for (genvar k = 0; k < BM_COUNT; k++) begin : g_metric
        localparam int unsigned UBIT = info_bit(k);
        localparam int unsigned PBIT = par_bit(k);

        logic signed [OUT_W-1:0] term_ext;
        logic signed [OUT_W-1:0] pos_val;
        logic signed [OUT_W-1:0] fin_val;

        // Equal information and parity bits use the sum, otherwise the difference.
        if (UBIT == PBIT) begin : g_sum
            assign term_ext = OUT_W'(sum_in);
        end else begin : g_diff
            assign term_ext = OUT_W'(diff_in);
        end

        assign pos_val = OUT_W'(half_in) + term_ext;

        // Information bit zero takes the two's complement (invert plus one).
        if (UBIT == 0) begin : g_neg
            assign fin_val = ~pos_val + OUT_W'(1);
        end else begin : g_pos
            assign fin_val = pos_val;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bm_q[k] <= '0;
            end else if (v_in) begin
                bm_q[k] <= fin_val;
            end
        end
    end

    // R5: the two sum-based metrics are exact negatives of each other
    p_sum_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        v_q |-> (int'(bm_q[BM_U0_P0]) + int'(bm_q[BM_U1_P1])) == 0);

    // R4: the two difference-based metrics are exact negatives of each other
    p_diff_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        v_q |-> (int'(bm_q[BM_U0_P1]) + int'(bm_q[BM_U1_P0])) == 0);

endmodule

// File: rtl/bm_parent_unit.sv
module bm_parent_unit
    import bm_pkg::*;
#(
    parameter int unsigned LLR_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic signed [LLR_W-1:0]   apriori_llr,
    input  logic signed [LLR_W-1:0]   sys_llr,
    input  logic signed [LLR_W-1:0]   par_llr,
    output logic                      out_valid,
    output logic signed [LLR_W+1:0]   bm_u0p0,
    output logic signed [LLR_W+1:0]   bm_u0p1,
    output logic signed [LLR_W+1:0]   bm_u1p0,
    output logic signed [LLR_W+1:0]   bm_u1p1
);

    localparam int unsigned SUM_W = LLR_W + 1;
    localparam int unsigned OUT_W = LLR_W + 2;

    logic                    s1_valid;
    logic signed [LLR_W-1:0] s1_half;
    logic signed [SUM_W-1:0] s1_sum;
    logic signed [SUM_W-1:0] s1_diff;
    logic signed [OUT_W-1:0] s2_bm [BM_COUNT];

    bm_front_stage #(
        .LLR_W (LLR_W),
        .SUM_W (SUM_W)
    ) u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .la_in    (apriori_llr),
        .ls_in    (sys_llr),
        .lp_in    (par_llr),
        .v_q      (s1_valid),
        .half_q   (s1_half),
        .sum_q    (s1_sum),
        .diff_q   (s1_diff)
    );

    bm_sign_stage #(
        .LLR_W (LLR_W),
        .SUM_W (SUM_W),
        .OUT_W (OUT_W)
    ) u_sign (
        .clk     (clk),
        .rst_n   (rst_n),
        .v_in    (s1_valid),
        .half_in (s1_half),
        .sum_in  (s1_sum),
        .diff_in (s1_diff),
        .v_q     (out_valid),
        .bm_q    (s2_bm)
    );

    assign bm_u0p0 = s2_bm[BM_U0_P0];
    assign bm_u0p1 = s2_bm[BM_U0_P1];
    assign bm_u1p0 = s2_bm[BM_U1_P0];
    assign bm_u1p1 = s2_bm[BM_U1_P1];

    // Cycles since reset release, saturating at the pipeline depth;
    // keeps two-cycle look-backs inside the post-reset history.
    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm_q <= 2'd0;
        end else if (warm_q != 2'(BM_LATENCY)) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    // R6: valid emerges exactly two cycles after it enters
    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'(BM_LATENCY)) |-> (out_valid == $past(in_valid, 2)));

    // R2: end-to-end value of the all-ones metric
    p_metric_u1p1_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'(BM_LATENCY)) && out_valid |->
            int'(bm_u1p1) == int'($past(apriori_llr, 2) >>> 1)
                           + int'($past(sys_llr, 2)) + int'($past(par_llr, 2)));

    // R7: without a new sample the metrics do not move
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q != 2'd0) && !out_valid |->
            $stable(bm_u1p1) && $stable(bm_u1p0) && $stable(bm_u0p1) && $stable(bm_u0p0));

    // R1: metrics are zero until the first valid sample has passed
    p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd0) |-> (bm_u1p1 == '0) && (bm_u0p0 == '0) && !out_valid);

endmodule

// File: tb/bm_parent_unit_bench.sv
`timescale 1ns/1ps
module bm_parent_unit_bench;

    localparam int LLR_W = 8;
    localparam int NVEC  = 10;
    // {a-priori, systematic, parity}
    localparam int VEC [NVEC][3] = '{
        '{  10,    3,    2},
        '{  -3,    5,   -7},
        '{   7,  -20,   15},
        '{-128, -128, -128},
        '{ 127,  127,  127},
        '{-128,  127, -128},
        '{ 127, -128,  127},
        '{   0,    0,    0},
        '{  -1,   -1,    1},
        '{  64,  -50,  -50}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [LLR_W-1:0] apriori_llr = '0;
    logic signed [LLR_W-1:0] sys_llr = '0;
    logic signed [LLR_W-1:0] par_llr = '0;
    logic out_valid;
    logic signed [LLR_W+1:0] bm_u0p0, bm_u0p1, bm_u1p0, bm_u1p1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bm_parent_unit #(.LLR_W(LLR_W)) u_bm_parent_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .apriori_llr (apriori_llr),
        .sys_llr     (sys_llr),
        .par_llr     (par_llr),
        .out_valid   (out_valid),
        .bm_u0p0     (bm_u0p0),
        .bm_u0p1     (bm_u0p1),
        .bm_u1p0     (bm_u1p0),
        .bm_u1p1     (bm_u1p1)
    );

    function automatic int floor_half(int v);
        if (v < 0 && (v % 2) != 0) return v / 2 - 1;
        return v / 2;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(int la, int s, int p, logic v);
        apriori_llr = LLR_W'(la);
        sys_llr     = LLR_W'(s);
        par_llr     = LLR_W'(p);
        in_valid    = v;
    endtask

    task automatic check_vec(int i);
        int h;
        h = floor_half(VEC[i][0]);
        check("R6 out_valid", int'(out_valid), 1);
        check("R2 bm_u1p1", int'(bm_u1p1), h + VEC[i][1] + VEC[i][2]);
        check("R3 bm_u1p0", int'(bm_u1p0), h + VEC[i][1] - VEC[i][2]);
        check("R4 bm_u0p1", int'(bm_u0p1), -h - VEC[i][1] + VEC[i][2]);
        check("R5 bm_u0p0", int'(bm_u0p0), -h - VEC[i][1] - VEC[i][2]);
    endtask

    task automatic check_zero(string tag);
        check(tag, int'(out_valid), 0);
        check(tag, int'(bm_u1p1), 0);
        check(tag, int'(bm_u1p0), 0);
        check(tag, int'(bm_u0p1), 0);
        check(tag, int'(bm_u0p0), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state, even with valid data on the inputs
        drive(50, 40, 30, 1'b1);
        repeat (3) @(negedge clk);
        check_zero("R1 reset");
        drive(0, 0, 0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk, one vector per cycle (R2..R6, R8, R9)
        for (int i = 0; i < NVEC + 2; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                check_vec(i - 2);
                if (i - 2 >= 3 && i - 2 <= 6)
                    check("R8 full scale", int'(bm_u1p1),
                          floor_half(VEC[i-2][0]) + VEC[i-2][1] + VEC[i-2][2]);
                if (i - 2 == 1) check("R9 floor -3", int'(bm_u1p1), -2 + 5 - 7);
                if (i - 2 == 8) check("R9 floor -1", int'(bm_u1p1), -1 - 1 + 1);
            end
            if (i < NVEC) drive(VEC[i][0], VEC[i][1], VEC[i][2], 1'b1);
            else          drive(99, -77, 55, 1'b0);   // junk data, valid low
        end

        // R7: bubbles with junk data leave the last metrics in place
        for (int j = 0; j < 2; j++) begin
            @(negedge clk);
            check("R7 out_valid low", int'(out_valid), 0);
            check("R7 hold u1p1", int'(bm_u1p1), 64/2 - 50 - 50);
            check("R7 hold u0p1", int'(bm_u0p1), -32 + 50 - 50);
        end

        // R6: isolated pulse appears on exactly one cycle, two cycles later
        drive(-20, 9, 4, 1'b1);
        @(negedge clk);
        drive(1, 1, 1, 1'b0);
        check("R6 pulse +1", int'(out_valid), 0);
        @(negedge clk);
        check("R6 pulse +2", int'(out_valid), 1);
        check("R2 pulse value", int'(bm_u1p1), -10 + 9 + 4);
        check("R4 pulse value", int'(bm_u0p1), 10 - 9 + 4);
        @(negedge clk);
        check("R6 pulse +3", int'(out_valid), 0);
        check("R7 pulse hold", int'(bm_u1p0), -10 + 9 - 4);

        // R1: reset mid-stream clears the pipeline
        drive(100, 100, 100, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_zero("R1 mid-stream reset");
        drive(0, 0, 0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 after release", int'(out_valid), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule